// File: doc/BRIEF.md
# Calibration Sweep Engine

This block runs a single calibration pass over one digital tuning knob of an analog circuit. After a start pulse it drives each knob code in turn, from zero up to the largest code. At every code it waits a programmable number of settling cycles and then takes the next valid amplitude reading from the detector. It keeps the code that produced the strongest signal. The stimulus stays fixed for the whole pass.

A reading has two parts: a coarse range (mode) and an 8-bit fine level. The detector output falls as the amplitude rises, so a larger mode wins first. Within the same mode, a smaller level wins. During the sweep the knob carries the code under trial. Only when the pass is over does the knob receive the winning code. A one-cycle done pulse marks that moment, and the knob then keeps the winning code until the next pass.

Top module: `cal_sweep_engine`

## Requirements
- R1: Synchronous active-high reset drives knob_o to 0, busy_o to 0 and done_o to 0.
- R2: A start_i sampled high while idle raises busy_o on that same edge. During the pass knob_o shows the trial codes 0, 1, … up to 2**CODE_W-1 in ascending order. Each trial code appears one edge after the previous code was judged.
- R3: The settle count is latched when start_i is accepted. After knob_o takes a trial code, any valid reading sampled at one of the next settle+1 edges is ignored. The first edge that can accept a reading is settle+2 edges after the knob change.
- R4: For each trial code exactly one reading is used: the first one with det_valid_i high once settling is over.
- R5: One reading ranks above another if its det_mode_i is larger. When the modes are equal, it ranks above if its det_level_i is smaller.
- R6: When two codes give equal readings, the lower code is kept.
- R7: The edge after the last code is judged puts the winning code on knob_o and raises done_o together. done_o lasts exactly one cycle, and busy_o falls on the edge that ends it.
- R8: A start_i sampled while a pass is running, and any change of settle_cycles_i during a pass, have no effect on that pass.
- R9: While idle, knob_o holds its value (the last winning code, or 0 after reset) until the next pass loads a trial code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a pass (acted on only when idle) |
| settle_cycles_i | input | SETTLE_W | Settling wait, latched at start |
| det_valid_i | input | 1 | Detector reading valid |
| det_mode_i | input | MODE_W | Detector range; larger means stronger signal |
| det_level_i | input | LEVEL_W | Detector fine level; smaller means stronger signal |
| knob_o | output | CODE_W | Tuning code driven to the circuit |
| busy_o | output | 1 | High while a pass is in progress |
| done_o | output | 1 | One-cycle pulse when the winning code is applied |

## Verification
A wrong sequencing state moves the time at which knob_o steps to the next code. Because the bench compares knob_o, busy_o and done_o on every cycle, such a fault shows up on the very next code change. A bad settle counter, or a reading taken too early, shifts every later step by at least one cycle. A wrong ranking or tie rule leaves the timing intact, and it is caught only when the final code appears together with done_o at the end of the pass. Misleading readings are sent during settling so that early sampling changes the winner.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SET     = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_MEASURE = 3'd3,
    ST_COMPARE = 3'd4,
    ST_APPLY   = 3'd5,
    ST_DONE    = 3'd6
  } sweep_state_t;

  // candidate (mode a, level a) beats incumbent (mode b, level b)
  function automatic logic ranks_above(input logic [7:0] mode_a, input logic [15:0] lvl_a,
                                       input logic [7:0] mode_b, input logic [15:0] lvl_b);
    if (mode_a != mode_b) return mode_a > mode_b;
    return lvl_a < lvl_b;
  endfunction
endpackage

// File: rtl/cal_settle_timer.sv
module cal_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [SETTLE_W-1:0] load_val_i,
  input  logic                run_i,
  output logic                expired_o
);
  logic [SETTLE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  // R3: the wait shrinks by one each settling cycle
  p_settle_countdown_r3: assert property (@(posedge clk) disable iff (rst)
    (run_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cal_best_tracker.sv
module cal_best_tracker #(
  parameter int CODE_W  = 4,
  parameter int MODE_W  = 3,
  parameter int LEVEL_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear_i,
  input  logic               sample_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic               judge_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic [CODE_W-1:0]  best_code_o
);
  import cal_pkg::*;

  logic [MODE_W-1:0]  cap_mode_q, best_mode_q;
  logic [LEVEL_W-1:0] cap_level_q, best_level_q;
  logic               have_q;
  logic               wins;

  always_comb begin
    wins = !have_q || ranks_above(8'(cap_mode_q), 16'(cap_level_q),
                                  8'(best_mode_q), 16'(best_level_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_mode_q   <= '0;
      cap_level_q  <= '0;
      best_mode_q  <= '0;
      best_level_q <= '0;
      best_code_o  <= '0;
      have_q       <= 1'b0;
    end else begin
      if (clear_i) have_q <= 1'b0;
      if (sample_i) begin
        cap_mode_q  <= mode_i;
        cap_level_q <= level_i;
      end
      if (judge_i && wins) begin
        best_mode_q  <= cap_mode_q;
        best_level_q <= cap_level_q;
        best_code_o  <= code_i;
        have_q       <= 1'b1;
      end
    end
  end

  // R6: codes are tried in ascending order, so the kept code never exceeds the trial
  p_best_not_ahead_r6: assert property (@(posedge clk) disable iff (rst)
    have_q |-> (best_code_o <= code_i));
endmodule

// File: rtl/cal_sweep_ctrl.sv
module cal_sweep_ctrl #(
  parameter int CODE_W   = 4,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                det_valid_i,
  input  logic                timer_expired_i,
  input  logic [CODE_W-1:0]   best_code_i,
  output logic                timer_load_o,
  output logic [SETTLE_W-1:0] timer_val_o,
  output logic                timer_run_o,
  output logic                clear_o,
  output logic                sample_o,
  output logic                judge_o,
  output logic [CODE_W-1:0]   code_o,
  output logic [CODE_W-1:0]   knob_o,
  output logic                busy_o,
  output logic                done_o
);
  import cal_pkg::*;

  localparam logic [CODE_W-1:0] LAST_CODE = {CODE_W{1'b1}};

  sweep_state_t        state_q;
  logic [CODE_W-1:0]   code_q;
  logic [SETTLE_W-1:0] settle_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      code_q   <= '0;
      settle_q <= '0;
      knob_o   <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_SET;
          code_q   <= '0;
          settle_q <= settle_i;
          busy_o   <= 1'b1;
        end
        ST_SET: begin
          knob_o  <= code_q;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE:  if (timer_expired_i) state_q <= ST_MEASURE;
        ST_MEASURE: if (det_valid_i) state_q <= ST_COMPARE;
        ST_COMPARE: begin
          if (code_q == LAST_CODE) begin
            state_q <= ST_APPLY;
          end else begin
            code_q  <= code_q + 1'b1;
            state_q <= ST_SET;
          end
        end
        ST_APPLY: begin
          knob_o  <= best_code_i;
          done_o  <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: begin
          busy_o  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign timer_load_o = (state_q == ST_SET);
  assign timer_val_o  = settle_q;
  assign timer_run_o  = (state_q == ST_SETTLE);
  assign clear_o      = (state_q == ST_IDLE) && start_i;
  assign sample_o     = (state_q == ST_MEASURE) && det_valid_i;
  assign judge_o      = (state_q == ST_COMPARE);
  assign code_o       = code_q;

  // R7: done is a single-cycle pulse and comes while busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_o);
  // R2: trial codes ascend by one
  p_code_step_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COMPARE && code_q != LAST_CODE) |=> (code_q == CODE_W'($past(code_q) + 1'b1)));
  // R9: knob untouched while idle
  p_knob_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> $stable(knob_o));
  // R3: knob steady throughout settling
  p_knob_steady_settle_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE) |=> $stable(knob_o));
endmodule

// File: rtl/cal_sweep_engine.sv
module cal_sweep_engine #(
  parameter int CODE_W   = 4,
  parameter int MODE_W   = 3,
  parameter int LEVEL_W  = 8,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                det_valid_i,
  input  logic [MODE_W-1:0]   det_mode_i,
  input  logic [LEVEL_W-1:0]  det_level_i,
  output logic [CODE_W-1:0]   knob_o,
  output logic                busy_o,
  output logic                done_o
);
  logic                tmr_load, tmr_run, tmr_expired;
  logic [SETTLE_W-1:0] tmr_val;
  logic                trk_clear, trk_sample, trk_judge;
  logic [CODE_W-1:0]   trial_code, best_code;

  cal_sweep_ctrl #(.CODE_W(CODE_W), .SETTLE_W(SETTLE_W)) ctrl_i (
    .clk(clk), .rst(rst), .start_i(start_i), .settle_i(settle_cycles_i),
    .det_valid_i(det_valid_i), .timer_expired_i(tmr_expired), .best_code_i(best_code),
    .timer_load_o(tmr_load), .timer_val_o(tmr_val), .timer_run_o(tmr_run),
    .clear_o(trk_clear), .sample_o(trk_sample), .judge_o(trk_judge),
    .code_o(trial_code), .knob_o(knob_o), .busy_o(busy_o), .done_o(done_o)
  );

  cal_settle_timer #(.SETTLE_W(SETTLE_W)) timer_i (
    .clk(clk), .rst(rst), .load_i(tmr_load), .load_val_i(tmr_val),
    .run_i(tmr_run), .expired_o(tmr_expired)
  );

  cal_best_tracker #(.CODE_W(CODE_W), .MODE_W(MODE_W), .LEVEL_W(LEVEL_W)) track_i (
    .clk(clk), .rst(rst), .clear_i(trk_clear), .sample_i(trk_sample),
    .mode_i(det_mode_i), .level_i(det_level_i), .judge_i(trk_judge),
    .code_i(trial_code), .best_code_o(best_code)
  );
endmodule

// File: tb/cal_sweep_engine_tb.sv
module cal_sweep_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCODE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0] settle_in = '0;
  logic valid = 1'b0;
  logic [2:0] mode = '0;
  logic [7:0] level = '0;
  logic [3:0] knob;
  logic busy, done;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  logic [2:0] r_mode [NCODE];
  logic [7:0] r_lvl  [NCODE];

  // behavioural reference
  int m_phase, m_code, m_wait, m_knob, m_busy, m_done, m_best, m_bm, m_bl, m_cm, m_cl, m_settle;
  bit m_have;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_sweep_engine dut_i (
    .clk(clk), .rst(rst), .start_i(start), .settle_cycles_i(settle_in),
    .det_valid_i(valid), .det_mode_i(mode), .det_level_i(level),
    .knob_o(knob), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_phase = 0; m_code = 0; m_wait = 0; m_knob = 0; m_busy = 0; m_done = 0;
      m_best = 0; m_have = 0; m_bm = 0; m_bl = 0; m_cm = 0; m_cl = 0; m_settle = 0;
    end else begin
      case (m_phase)
        0: if (start) begin m_phase = 1; m_code = 0; m_have = 0; m_settle = settle_in; m_busy = 1; end
        1: begin m_knob = m_code; m_wait = m_settle; m_phase = 2; end
        2: if (m_wait == 0) m_phase = 3; else m_wait--;
        3: if (valid) begin m_cm = mode; m_cl = level; m_phase = 4; end
        4: begin
          if (!m_have || m_cm > m_bm || (m_cm == m_bm && m_cl < m_bl)) begin
            m_have = 1; m_bm = m_cm; m_bl = m_cl; m_best = m_code;
          end
          if (m_code == NCODE-1) m_phase = 5; else begin m_code++; m_phase = 1; end
        end
        5: begin m_knob = m_best; m_done = 1; m_phase = 6; end
        default: begin m_done = 0; m_busy = 0; m_phase = 0; end
      endcase
    end
    if (cyc > 150000 && !finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected end before 150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic compare_cycle();
    check("R2 knob_o trace", int'(knob), m_knob);
    check("R7 busy_o trace", int'(busy), m_busy);
    check("R7 done_o trace", int'(done), m_done);
  endtask

  function automatic int expected_winner();
    int b = 0;
    for (int c = 1; c < NCODE; c++)
      if (r_mode[c] > r_mode[b] || (r_mode[c] == r_mode[b] && r_lvl[c] < r_lvl[b])) b = c;
    return b;
  endfunction

  // run one pass: valid every 'period' cycles; decoys during settling; disturbances mid-pass
  task automatic run_pass(input int s, input int period, input bit decoy, input bit disturb,
                          input string req);
    int k = 0;
    int win = expected_winner();
    int seen_done = 0;
    @(negedge clk);
    compare_cycle();
    settle_in = 8'(s); start = 1'b1;
    @(negedge clk);
    compare_cycle();
    start = 1'b0;
    while (m_phase != 0 && k < 5000) begin
      k++;
      if (m_phase == 1 || m_phase == 2) begin
        valid = decoy; mode = 3'd7; level = 8'd0;
      end else begin
        valid = (k % period) == 0;
        mode = r_mode[m_knob % NCODE]; level = r_lvl[m_knob % NCODE];
      end
      if (disturb && (k % 7) == 3) begin start = 1'b1; settle_in = 8'(k % 11); end
      else start = 1'b0;
      @(negedge clk);
      compare_cycle();
      if (done) begin
        seen_done++;
        check({req, " final knob"}, int'(knob), win);
      end
    end
    start = 1'b0; valid = 1'b0;
    check("R7 one done pulse per pass", seen_done, 1);
  endtask

  initial begin
    for (int c = 0; c < NCODE; c++) begin r_mode[c] = 3'd2; r_lvl[c] = 8'(100 + c); end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset knob_o", int'(knob), 0);
    check("R1 reset busy_o", int'(busy), 0);
    check("R1 reset done_o", int'(done), 0);

    // R5: mode ranks first, then lowest level
    r_mode[9] = 3'd5; r_lvl[9] = 8'd200;
    r_mode[4] = 3'd5; r_lvl[4] = 8'd150;
    r_mode[12] = 3'd4; r_lvl[12] = 8'd10;
    run_pass(3, 1, 1'b0, 1'b0, "R5");
    check("R5 winner is code 4", int'(knob), 4);

    // R9: knob holds while idle
    repeat (8) begin @(negedge clk); check("R9 idle hold", int'(knob), 4); end

    // R6: tie keeps lower code; sparse valid for R4
    for (int c = 0; c < NCODE; c++) begin r_mode[c] = 3'd1; r_lvl[c] = 8'd100; end
    r_mode[6] = 3'd3; r_lvl[6] = 8'd40;
    r_mode[11] = 3'd3; r_lvl[11] = 8'd40;
    run_pass(1, 3, 1'b0, 1'b0, "R6");
    check("R6 tie winner is code 6", int'(knob), 6);

    // R3/R8: decoys while settling, start and settle changes mid-pass, best at last code
    for (int c = 0; c < NCODE; c++) begin r_mode[c] = 3'd0; r_lvl[c] = 8'(255 - c); end
    r_mode[15] = 3'd6; r_lvl[15] = 8'd90;
    run_pass(0, 4, 1'b1, 1'b1, "R3 R8");
    check("R3 decoys ignored, winner 15", int'(knob), 15);

    run_pass(4, 2, 1'b1, 1'b1, "R8");
    check("R8 restart attempts ignored, winner 15", int'(knob), 15);

    // R4/R6: all equal, code 0 wins
    for (int c = 0; c < NCODE; c++) begin r_mode[c] = 3'd3; r_lvl[c] = 8'd77; end
    run_pass(5, 2, 1'b1, 1'b0, "R4");
    check("R4 R6 equal readings keep code 0", int'(knob), 0);

    repeat (4) begin @(negedge clk); compare_cycle(); end
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule